// File: doc/BRIEF.md
# Bit-Banged Serial Register-Write Sequencer

This block converts one register write request, made of a 7-bit register address and an 8-bit value, into a sequence of byte-wide pin patterns. Each pattern carries three pin levels: chip-select in bit 7, serial clock in bit 6 and serial data in bit 5. A downstream consumer either applies each byte to the pins directly, one per master-clock tick, or writes the bytes into a byte memory that a simple sequential reader replays later. Either way, the receiving serial slave sees a complete write cycle.

The serial clock is not produced by a divider. Every clock level is written explicitly into the stream, so each serial bit takes two consecutive entries: the first has the clock low and presents the bit, and the second raises the clock while holding the same bit. A frame is always 35 entries long: one opening entry, 32 bit entries, and two closing entries. A requester raises `req` with the address and value and keeps it high until `ack` pulses. The consumer drives `tick` to set the rate at which entries are produced.

Top module: `bitbang_wr_seq`

## Requirements
- R1: After reset, `pat_vld` and `ack` are 0 and `pat` reads 0x80.
- R2: Entry 0 of every frame is 0x80: chip-select high, clock low, data low.
- R3: Entries 1 to 32 have chip-select low. Entry 2k+1 has the clock low and entry 2k+2 has the clock high, both carrying the same data bit k.
- R4: Serial bit 0 is the write flag and is always 0. Bits 1 to 7 are address bits 0 to 6, and bits 8 to 15 are data bits 0 to 7, so both fields go least significant bit first.
- R5: Entries 33 and 34 are both 0x80, so a frame is exactly 35 entries long.
- R6: Bits 4 to 0 of every valid pattern are 0.
- R7: One entry is output, with `pat_vld` high for one cycle, only in the cycle after an edge at which `tick` was high. While `tick` is low the frame stalls, with no entries skipped or repeated.
- R8: `ack` is a one-cycle pulse that coincides with entry 34. A request is accepted only at an edge where the block is idle and `ack` is low, so a `req` still held high during the `ack` cycle starts no extra frame. With `req` low, no entries are output.
- R9: `addr`, `wdata` and `req` are ignored from acceptance until the frame completes. The frame carries the values present at acceptance.
- R10: A request presented in the `ack` cycle is accepted two edges later. With `tick` held high, its entry 0 appears three cycles after `ack`, so the stream has no idle entries between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance-one-entry enable |
| req | input | 1 | Write request, held until ack |
| addr | input | 7 | Register address |
| wdata | input | 8 | Register value |
| ack | output | 1 | One-cycle frame-complete pulse |
| pat | output | 8 | Pin pattern: bit 7 chip-select, bit 6 clock, bit 5 data |
| pat_vld | output | 1 | Pattern valid strobe |

## Verification
A wrong entry index shows at once as a misplaced clock level, a missing pair partner or a shifted data bit. The very next valid pattern differs from the arithmetic reference. A corrupted captured word shows as a wrong data bit somewhere within the 32 bit entries of that same frame. A faulty busy or acknowledge state shows at the frame boundary: `ack` lands on the wrong entry, the stream runs past 35 entries, or a second frame starts without a fresh request within a few cycles of `ack`.

// File: rtl/bitbang_wr_seq.sv
module bitbang_wr_seq #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [7:0]        pat,
  output logic              pat_vld
);
  localparam int BITS    = 1 + ADDR_W + DATA_W;
  localparam int ENTRIES = 2 * BITS + 3;
  localparam int IW      = $clog2(ENTRIES);
  localparam logic [IW-1:0] LAST_BIT = IW'(2 * BITS);
  localparam logic [IW-1:0] LAST     = IW'(ENTRIES - 1);
  localparam logic [7:0]    IDLE_PAT = 8'h80;

  logic            busy;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   k;
  logic [BITS-1:0] word;
  logic [BITS-1:0] shifted;
  logic [7:0]      nxt;

  wire accept = req && !busy && !ack;

  assign k       = idx - IW'(1);
  assign shifted = word >> k[IW-1:1];

  always_comb begin
    nxt = IDLE_PAT;
    if (idx != '0 && idx <= LAST_BIT)
      nxt = {1'b0, k[0], shifted[0], 5'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      word    <= '0;
      pat     <= IDLE_PAT;
      pat_vld <= 1'b0;
      ack     <= 1'b0;
    end else begin
      pat_vld <= 1'b0;
      ack     <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
        word <= {wdata, addr, 1'b0};
      end else if (busy && tick) begin
        pat     <= nxt;
        pat_vld <= 1'b1;
        if (idx == LAST) begin
          busy <= 1'b0;
          ack  <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bitbang_wr_seq_chk.sv
module bitbang_wr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ack,
  input logic [7:0] pat,
  input logic       pat_vld
);
  logic [7:0] last_pat;

  always_ff @(posedge clk) begin
    if (!rst_n) last_pat <= 8'h80;
    else if (pat_vld) last_pat <= pat;
  end

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld |-> pat[4:0] == 5'b0); // R6
  AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld && pat[7] |-> pat[6:5] == 2'b00); // R2
  AST_RISE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld && pat[6] |-> !last_pat[7] && !last_pat[6] && last_pat[5] == pat[5]); // R3
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld |-> $past(tick)); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R8
  AST_ACK_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pat_vld && pat == 8'h80); // R5
endmodule

bind bitbang_wr_seq bitbang_wr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ack(ack), .pat(pat), .pat_vld(pat_vld)
);

// File: tb/bitbang_wr_seq_tb.sv
module bitbang_wr_seq_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic req = 0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ack;
  logic [7:0] pat;
  logic pat_vld;

  bitbang_wr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .addr(addr),
    .wdata(wdata), .ack(ack), .pat(pat), .pat_vld(pat_vld)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mon_on = 0;
  int tmode = 0;
  logic [6:0] fa [0:399];
  logic [7:0] fd [0:399];
  bit         fb [0:399];
  int fnum = 0;
  int ent = 0;
  int gap = 0;
  int cyc = 0;
  logic tick_q = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (frame %0d entry %0d)", tag, act, exp, fnum, ent);
    end
  endtask

  function automatic logic [7:0] expp(input logic [6:0] a, input logic [7:0] d, input int i);
    logic [15:0] w;
    int kk;
    w = {d, a, 1'b0};
    if (i == 0 || i >= 33) return 8'h80;
    kk = i - 1;
    return {1'b0, kk[0], w[kk / 2], 5'b0};
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (pat_vld) begin
        chk(tick_q == 1'b1, "R7", 0, 1);
        if (ent == 0) chk(pat == expp(fa[fnum], fd[fnum], ent), "R2", pat, expp(fa[fnum], fd[fnum], ent));
        else if (ent <= 32) chk(pat == expp(fa[fnum], fd[fnum], ent), "R3 R4 R6", pat, expp(fa[fnum], fd[fnum], ent));
        else chk(pat == expp(fa[fnum], fd[fnum], ent), "R5", pat, expp(fa[fnum], fd[fnum], ent));
        chk(ack == (ent == 34), "R8", ack, ent == 34);
        if (ent == 0 && fnum > 0 && fb[fnum]) chk(gap == 2, "R10", gap, 2);
        ent++;
        if (ent == 35) begin
          ent = 0;
          fnum++;
          gap = 0;
        end
      end else begin
        chk(ack == 1'b0, "R8", ack, 0);
        gap++;
      end
    end
    tick_q = (tmode == 0) ? 1'b1 : (cyc % 3 == 0);
    tick = tick_q;
    cyc++;
  end

  task automatic send(input int n, input logic [6:0] a, input logic [7:0] d, input bit b2b);
    fa[n] = a;
    fd[n] = d;
    fb[n] = b2b;
    addr = a;
    wdata = d;
    req = 1'b1;
    @(negedge clk);
    while (!pat_vld) @(negedge clk);
    addr = ~a;
    wdata = ~d;
    while (!ack) @(negedge clk);
  endtask

  initial begin
    int n;
    int seen;
    n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pat_vld == 1'b0, "R1", pat_vld, 0);
    chk(ack == 1'b0, "R1", ack, 0);
    chk(pat == 8'h80, "R1", pat, 8'h80);
    mon_on = 1'b1;
    // R9: inputs flipped mid-frame; R10: immediate re-request with continuous tick
    for (int a = 0; a < 128; a++) begin
      send(n, 7'(a), 8'(a * 5 + 3), a > 0);
      n++;
    end
    tmode = 1;
    // R7: stalled ticks, sweep of all data values
    for (int d = 0; d < 256; d++) begin
      send(n, 7'(d >> 1) ^ 7'h2a, 8'(d), 1'b0);
      n++;
    end
    req = 1'b0;
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (pat_vld) seen++;
    end
    chk(seen == 0, "R8", seen, 0);
    chk(fnum == n, "R5", fnum, n);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", fnum, 384);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule